// File: doc/BRIEF.md
# Prioritized Interrupt and Exception Vectoring

This block is the exception entry logic of a processor with two privilege levels. Each cycle it looks at a 3-bit encoded interrupt request level and compares it with the interrupt mask held in the status register. When a request is accepted, the block opens an acknowledge phase and waits for the peripheral side to answer. The answer can be a supplied vector number, an autovector request, or a spurious/timeout indication. The block then pulses `take_exc` together with the vector number and the vector's byte address in the 1024-byte vector table.

The same entry path serves software traps, which carry a 4-bit trap number, and the two-step reset sequence that fetches the initial stack pointer and program counter. Every entry forces the supervisor bit. On an interrupt entry the mask is also raised to the level that was taken. The status register as it stood before entry is presented for stacking.

Two stack pointer registers are kept, one for user mode and one for supervisor mode. The supervisor bit selects which of them is active. Because entry sets that bit, the active stack moves to the supervisor stack at the same moment.

Top module: `exc_vector_unit`

## Requirements
- R1: While `rst_n` is low, `sr_q` reads 16'h2700 (supervisor bit 13 set, mask field bits 10:8 equal to 7), and both `take_exc` and `iack_req` are low.
- R2: After reset is released, `take_exc` is high on the first cycle with vector 0 and address 0. It is high on the second cycle with vector 1 and address 4. On the third cycle it is low.
- R3: A request of level 1 to 6 is accepted only when the level is greater than the mask in `sr_q[10:8]`. Acceptance shows as `iack_req` high, with `iack_lvl` equal to the level, in the cycle after the level was sampled. A level of 0 means no request.
- R4: Level 7 is accepted on a transition to 7 from any lower level, whatever the mask. Holding level 7 does not cause a second acceptance, even if the mask is lowered. A transition that occurs while the block is busy is remembered and taken once the block is idle.
- R5: While `iack_req` is high, `ack_valid` ends the acknowledge phase, and `take_exc` is high for exactly one cycle after that. The vector number depends on `ack_kind`: 0 uses `ack_vec`, 1 gives 24 plus the level, and 2 or 3 (spurious/timeout) gives 24.
- R6: Whenever `take_exc` is high, `vec_addr` equals `vec_num` times 4.
- R7: On an interrupt entry, `sr_q` takes the mask equal to the accepted level and has bit 13 set, while its other bits are kept. `sr_stacked` holds the value `sr_q` had before entry.
- R8: When idle, `trap_req` gives `take_exc` in the next cycle with vector 32 plus `trap_num`. The entry sets bit 13, leaves the mask unchanged, and stacks the prior status register.
- R9: When an interrupt is accepted in the same cycle as a trap request, the interrupt wins and the trap is dropped. A `trap_req` that arrives while not idle is ignored and is not remembered.
- R10: `sp_q` shows the supervisor stack pointer when `sr_q[13]` is 1 and the user stack pointer otherwise. `sp_wr_en` writes the active one, and any exception entry switches `sp_q` to the supervisor stack pointer.
- R11: `sr_load` replaces `sr_q` with `sr_wr_data` in the next cycle when the block is idle and no exception is entered. During an acknowledge phase it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; release starts the reset vector sequence |
| irq_lvl | input | 3 | Encoded interrupt request level, 0 = none |
| ack_valid | input | 1 | Acknowledge response present |
| ack_kind | input | 2 | 0 vectored, 1 autovector, 2/3 spurious or timeout |
| ack_vec | input | 8 | Vector number supplied with a vectored response |
| trap_req | input | 1 | Software trap request |
| trap_num | input | 4 | Trap number |
| sr_load | input | 1 | Status register write strobe |
| sr_wr_data | input | 16 | Status register write value |
| sp_wr_en | input | 1 | Write the active stack pointer |
| sp_wr_data | input | SP_W | Stack pointer write value |
| take_exc | output | 1 | One-cycle exception entry pulse |
| vec_num | output | 8 | Vector number of the entry |
| vec_addr | output | VA_W | Vector table byte address |
| sr_q | output | 16 | Current status register |
| sr_stacked | output | 16 | Status register value before the entry, for stacking |
| iack_req | output | 1 | Acknowledge phase in progress |
| iack_lvl | output | 3 | Level being acknowledged |
| sp_q | output | SP_W | Active stack pointer |

## Verification
`iack_req` appears one cycle after the level is sampled. `take_exc`, `vec_num`, `vec_addr`, `sr_q` and `sr_stacked` all change in the cycle after the edge at which `ack_valid` or an idle `trap_req` was sampled. `sp_q` follows the new supervisor bit in that same cycle. The reset vectors appear in the first and second cycles after release. Inputs are driven on the falling edge, and every output is read on the next falling edge or a counted number of falling edges later, so each check lands in the cycle in which its result is due. The sweeps cover every mask against every level 1 to 6 with all three response kinds, and all sixteen trap numbers.

// File: rtl/exc_vector_unit.sv
module exc_vector_unit #(
  parameter int SP_W = 32,
  parameter int VA_W = 32,
  parameter logic [15:0] SR_RST = 16'h2700
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      irq_lvl,
  input  logic            ack_valid,
  input  logic [1:0]      ack_kind,
  input  logic [7:0]      ack_vec,
  input  logic            trap_req,
  input  logic [3:0]      trap_num,
  input  logic            sr_load,
  input  logic [15:0]     sr_wr_data,
  input  logic            sp_wr_en,
  input  logic [SP_W-1:0] sp_wr_data,
  output logic            take_exc,
  output logic [7:0]      vec_num,
  output logic [VA_W-1:0] vec_addr,
  output logic [15:0]     sr_q,
  output logic [15:0]     sr_stacked,
  output logic            iack_req,
  output logic [2:0]      iack_lvl,
  output logic [SP_W-1:0] sp_q
);
  localparam int SBIT = 13;
  localparam logic [7:0] V_SPUR = 8'd24;
  localparam logic [7:0] V_TRAP = 8'd32;

  typedef enum logic [1:0] {ST_RST0, ST_RST1, ST_IDLE, ST_ACK} st_t;
  st_t state;

  logic [2:0]      lvl_prev, lvl_held;
  logic            nmi_pend;
  logic [SP_W-1:0] usp, ssp;

  wire [2:0] mask   = sr_q[10:8];
  wire       nmi_ev = (irq_lvl == 3'd7) && (lvl_prev != 3'd7);
  wire       nmi_go = nmi_pend || nmi_ev;
  wire       low_go = (irq_lvl != 3'd0) && (irq_lvl != 3'd7) && (irq_lvl > mask);
  wire       int_go = (state == ST_IDLE) && (nmi_go || low_go);
  wire [2:0] int_lv = nmi_go ? 3'd7 : irq_lvl;
  wire       trp_go = (state == ST_IDLE) && !int_go && trap_req;
  wire       ack_go = (state == ST_ACK) && ack_valid;

  logic [7:0] ack_sel;
  always_comb begin
    case (ack_kind)
      2'd0:    ack_sel = ack_vec;
      2'd1:    ack_sel = V_SPUR + {5'd0, lvl_held};
      default: ack_sel = V_SPUR;
    endcase
  end

  logic       nxt_take;
  logic [7:0] nxt_vec;
  always_comb begin
    nxt_take = 1'b0;
    nxt_vec  = vec_num;
    case (state)
      ST_RST0: begin nxt_take = 1'b1; nxt_vec = 8'd0; end
      ST_RST1: begin nxt_take = 1'b1; nxt_vec = 8'd1; end
      ST_IDLE: if (trp_go) begin nxt_take = 1'b1; nxt_vec = V_TRAP + {4'd0, trap_num}; end
      ST_ACK:  if (ack_go) begin nxt_take = 1'b1; nxt_vec = ack_sel; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RST0;
      sr_q       <= SR_RST;
      sr_stacked <= SR_RST;
      take_exc   <= 1'b0;
      vec_num    <= 8'd0;
      vec_addr   <= '0;
      lvl_prev   <= 3'd0;
      lvl_held   <= 3'd0;
      nmi_pend   <= 1'b0;
    end else begin
      take_exc <= nxt_take;
      lvl_prev <= irq_lvl;
      if (nxt_take) begin
        vec_num    <= nxt_vec;
        vec_addr   <= VA_W'({nxt_vec, 2'b00});
        sr_stacked <= sr_q;
      end
      if (nmi_ev) nmi_pend <= 1'b1;
      case (state)
        ST_RST0: state <= ST_RST1;
        ST_RST1: state <= ST_IDLE;
        ST_IDLE: begin
          if (int_go) begin
            state    <= ST_ACK;
            lvl_held <= int_lv;
            if (nmi_go) nmi_pend <= 1'b0;
          end else if (trp_go) begin
            sr_q[SBIT] <= 1'b1;
          end else if (sr_load) begin
            sr_q <= sr_wr_data;
          end
        end
        ST_ACK: if (ack_go) begin
          state      <= ST_IDLE;
          sr_q[SBIT] <= 1'b1;
          sr_q[10:8] <= lvl_held;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usp <= '0;
      ssp <= '0;
    end else if (sp_wr_en) begin
      if (sr_q[SBIT]) ssp <= sp_wr_data;
      else            usp <= sp_wr_data;
    end
  end

  assign sp_q     = sr_q[SBIT] ? ssp : usp;
  assign iack_req = (state == ST_ACK);
  assign iack_lvl = lvl_held;
endmodule

module exc_vector_unit_chk #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ack_valid,
  input logic            take_exc,
  input logic [7:0]      vec_num,
  input logic [VA_W-1:0] vec_addr,
  input logic [15:0]     sr_q,
  input logic [15:0]     sr_stacked,
  input logic            iack_req,
  input logic [2:0]      iack_lvl
);
  a_r5_ack_ends: assert property (@(posedge clk) disable iff (!rst_n)
    iack_req && ack_valid |=> take_exc && !iack_req);
  a_r5_ack_waits: assert property (@(posedge clk) disable iff (!rst_n)
    iack_req && !ack_valid |=> iack_req && !take_exc);
  a_r6_vec_addr: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> vec_addr == VA_W'({vec_num, 2'b00}));
  a_r7_stacked: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> sr_stacked == $past(sr_q));
  a_r7_mask_raised: assert property (@(posedge clk) disable iff (!rst_n)
    iack_req && ack_valid |=> sr_q[10:8] == $past(iack_lvl));
  a_r10_supervisor: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> sr_q[13]);
  a_r3_level_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    iack_req |-> iack_lvl != 3'd0);
endmodule

bind exc_vector_unit exc_vector_unit_chk #(.VA_W(VA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .take_exc(take_exc),
  .vec_num(vec_num), .vec_addr(vec_addr), .sr_q(sr_q), .sr_stacked(sr_stacked),
  .iack_req(iack_req), .iack_lvl(iack_lvl)
);

// File: tb/exc_vector_unit_bench.sv
module exc_vector_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  irq_lvl = 3'd0;
  logic        ack_valid = 1'b0;
  logic [1:0]  ack_kind = 2'd0;
  logic [7:0]  ack_vec = 8'd0;
  logic        trap_req = 1'b0;
  logic [3:0]  trap_num = 4'd0;
  logic        sr_load = 1'b0;
  logic [15:0] sr_wr_data = 16'd0;
  logic        sp_wr_en = 1'b0;
  logic [31:0] sp_wr_data = 32'd0;
  logic        take_exc;
  logic [7:0]  vec_num;
  logic [31:0] vec_addr;
  logic [15:0] sr_q, sr_stacked;
  logic        iack_req;
  logic [2:0]  iack_lvl;
  logic [31:0] sp_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  localparam logic [31:0] SSP_V = 32'hA5A5_0000;
  localparam logic [31:0] USP_V = 32'h1111_0000;

  always #2 clk = ~clk;

  exc_vector_unit u_exc_vector_unit (
    .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .ack_valid(ack_valid),
    .ack_kind(ack_kind), .ack_vec(ack_vec), .trap_req(trap_req), .trap_num(trap_num),
    .sr_load(sr_load), .sr_wr_data(sr_wr_data), .sp_wr_en(sp_wr_en),
    .sp_wr_data(sp_wr_data), .take_exc(take_exc), .vec_num(vec_num),
    .vec_addr(vec_addr), .sr_q(sr_q), .sr_stacked(sr_stacked), .iack_req(iack_req),
    .iack_lvl(iack_lvl), .sp_q(sp_q)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic load_sr(input logic [15:0] v);
    sr_load = 1'b1; sr_wr_data = v; step(); sr_load = 1'b0;
  endtask

  task automatic ack(input logic [1:0] k, input logic [7:0] v);
    ack_valid = 1'b1; ack_kind = k; ack_vec = v; step(); ack_valid = 1'b0;
  endtask

  task automatic run();
    logic [15:0] old;
    logic [7:0]  ev;
    step(); step();
    chk(sr_q == 16'h2700, "R1 sr reset", sr_q, 16'h2700);
    chk(!take_exc && !iack_req, "R1 idle outputs", {take_exc, iack_req}, 0);
    rst_n = 1'b1;
    step();
    chk(take_exc && vec_num == 0 && vec_addr == 0, "R2 vector 0", {vec_num, 3'b0, take_exc}, 1);
    step();
    chk(take_exc && vec_num == 1 && vec_addr == 4, "R2 vector 1", vec_addr, 4);
    step();
    chk(!take_exc, "R2 sequence ends", take_exc, 0);

    sp_wr_en = 1'b1; sp_wr_data = SSP_V; step(); sp_wr_en = 1'b0;
    chk(sp_q == SSP_V, "R10 supervisor sp write", sp_q, SSP_V);
    load_sr(16'h0000);
    chk(sr_q == 16'h0000, "R11 sr load", sr_q, 0);
    chk(sp_q == 32'd0, "R10 user sp selected", sp_q, 0);
    sp_wr_en = 1'b1; sp_wr_data = USP_V; step(); sp_wr_en = 1'b0;
    chk(sp_q == USP_V, "R10 user sp write", sp_q, USP_V);

    for (int m = 0; m < 8; m++) begin
      for (int l = 1; l < 7; l++) begin
        int k;
        k = (m + l) % 3;
        old = 16'h001F | 16'(m << 8);
        load_sr(old);
        irq_lvl = 3'(l); step(); irq_lvl = 3'd0;
        chk(iack_req == (l > m), "R3 accept vs mask", iack_req, 32'(l > m));
        if (l > m) begin
          chk(iack_lvl == 3'(l) && !take_exc, "R3 level shown", iack_lvl, l);
          sr_load = 1'b1; sr_wr_data = 16'h0000; step(); sr_load = 1'b0;
          chk(sr_q == old && iack_req, "R11 load ignored in ack", sr_q, old);
          ev = (k == 0) ? 8'(8'h40 + m * 8 + l) : (k == 1) ? 8'(24 + l) : 8'd24;
          ack(2'(k == 2 ? 2 + (m % 2) : k), 8'(8'h40 + m * 8 + l));
          chk(take_exc && vec_num == ev, "R5 vector select", vec_num, ev);
          chk(vec_addr == 32'(ev) * 4, "R6 byte address", vec_addr, 32'(ev) * 4);
          chk(sr_q == ((old & 16'hF8FF) | 16'h2000 | 16'(l << 8)), "R7 new sr", sr_q,
              (old & 16'hF8FF) | 16'h2000 | 16'(l << 8));
          chk(sr_stacked == old, "R7 stacked sr", sr_stacked, old);
          chk(sp_q == SSP_V, "R10 swap on entry", sp_q, SSP_V);
          step();
          chk(!take_exc, "R5 single pulse", take_exc, 0);
        end else begin
          step();
          chk(!iack_req && !take_exc, "R3 masked stays quiet", iack_req, 0);
        end
      end
    end

    load_sr(16'h2700);
    irq_lvl = 3'd7; step();
    chk(iack_req && iack_lvl == 7, "R4 level 7 past mask 7", iack_lvl, 7);
    ack(2'd1, 8'd0);
    chk(take_exc && vec_num == 31, "R4 level 7 autovector", vec_num, 31);
    load_sr(16'h0000);
    step();
    chk(!iack_req, "R4 held level 7 not retaken", iack_req, 0);
    irq_lvl = 3'd0; step();
    irq_lvl = 3'd7; step();
    chk(iack_req && iack_lvl == 7, "R4 new rise taken", iack_req, 1);
    ack(2'd0, 8'h99);
    chk(take_exc && vec_num == 8'h99 && vec_addr == 32'h264, "R6 vectored address", vec_addr, 32'h264);

    irq_lvl = 3'd0; load_sr(16'h0000);
    irq_lvl = 3'd3; step(); irq_lvl = 3'd0;
    chk(iack_req && iack_lvl == 3, "R3 level 3 taken", iack_lvl, 3);
    irq_lvl = 3'd7; step(); irq_lvl = 3'd0; step();
    ack(2'd1, 8'd0);
    chk(take_exc && vec_num == 27, "R5 autovector level 3", vec_num, 27);
    step();
    chk(iack_req && iack_lvl == 7, "R4 remembered rise", iack_lvl, 7);
    ack(2'd2, 8'd0);
    chk(take_exc && vec_num == 24 && sr_q[10:8] == 7, "R5 spurious vector", vec_num, 24);

    for (int n = 0; n < 16; n++) begin
      old = 16'h0005 | 16'((n % 8) << 8);
      load_sr(old);
      trap_req = 1'b1; trap_num = 4'(n); step(); trap_req = 1'b0;
      chk(take_exc && vec_num == 8'(32 + n), "R8 trap vector", vec_num, 32 + n);
      chk(vec_addr == 32'((32 + n) * 4), "R6 trap address", vec_addr, (32 + n) * 4);
      chk(sr_q == (old | 16'h2000) && sr_stacked == old, "R8 trap sr", sr_q, old | 16'h2000);
      chk(sp_q == SSP_V, "R10 trap uses ssp", sp_q, SSP_V);
    end

    load_sr(16'h0000);
    irq_lvl = 3'd2; trap_req = 1'b1; trap_num = 4'd5; step();
    irq_lvl = 3'd0; trap_req = 1'b0;
    chk(iack_req && !take_exc, "R9 interrupt wins", {iack_req, take_exc}, 2);
    trap_req = 1'b1; step(); trap_req = 1'b0;
    ack(2'd1, 8'd0);
    chk(take_exc && vec_num == 26, "R9 interrupt completes", vec_num, 26);
    step();
    chk(!take_exc && !iack_req, "R9 trap in ack ignored", take_exc, 0);
    step();
    chk(!take_exc, "R9 trap not remembered", take_exc, 0);
  endtask

  initial begin
    fork
      begin run(); done = 1; end
      begin repeat (20000) @(posedge clk); end
    join_any
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule